// File: doc/BRIEF.md
# Dual-Issue Pair Steering Unit

This unit sits between decode and execute in a two-wide in-order pipeline. Each cycle the fetch stage presents two decoded instructions taken from consecutive words, the older in slot 0 and the younger in slot 1. The unit decides which of the two may issue and routes each issued instruction to one of two execution units. The two units split the operation classes between them: one runs arithmetic operations and the other runs logic operations. The unit also selects which issued instruction drives the single data-memory port, and tells fetch how far to move the program counter.

The younger instruction is held back whenever the pair cannot go together. That happens when both need the same unit class, when both access memory, when both write the same register, or when the younger reads a register that the older writes. In that case only the older instruction issues and fetch moves forward by one instruction. The held instruction therefore comes back next cycle as the older slot of a new pair, so a second memory access takes the port one cycle after the first. Register index 0 never creates a dependency. A downstream stall blocks all issue and keeps the PC where it is.

The issue grants, unit selects and memory-port select are registered and appear on the clock edge after the pair is presented. The PC increment is combinational, so fetch can use it in the same cycle.

Top module: `dsp_pair_steer`

## Requirements
- R1: While reset is asserted, and from then until the first decision after reset is released, `gnt`, `unit_sel` and `mem_en` are all zero. Asserting `rst_n` low clears them at once, without waiting for a clock edge.
- R2: An issued instruction is routed by its class bit (0 = arithmetic, 1 = logic). `unit_sel[i]` is 1 only when slot i is granted and its class is logic. It is 0 for an issued arithmetic instruction and for any slot that is not granted.
- R3: When both slots are valid and carry the same class bit, only slot 0 is granted (`gnt` = 2'b01).
- R4: Only one instruction may use the memory port. When both valid slots have their memory flag set, only slot 0 is granted, with `mem_en`=1 and `mem_slot`=0. When the only issued memory access is in slot 1, `mem_slot`=1.
- R5: When both slots are valid and write the same nonzero destination index, slot 1 is not granted. This keeps the younger write after the older one.
- R6: When either source index of slot 1 equals the nonzero destination index of a valid slot 0, slot 1 is not granted.
- R7: Register index 0 creates no dependency. A slot-0 destination of 0 blocks slot 1 neither through a source match nor through a destination match.
- R8: While `stall_in` is 1, no slot is granted, `mem_en` is 0 and `fetch_inc` is 0.
- R9: When there is no stall, `fetch_inc` is 2*INSN_BYTES if slot 1 is granted or invalid, and INSN_BYTES if a valid slot 1 is held. An invalid slot counts as consumed, and a valid slot 0 is always granted when there is no stall.
- R10: `gnt`, `unit_sel`, `mem_en` and `mem_slot` change only on the clock edge after the pair that produced them. `fetch_inc` follows the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 1 | Slot 0 class: 0 arithmetic, 1 logic |
| s0_mem | input | 1 | Slot 0 accesses data memory |
| s0_dst | input | REG_IDX_W | Slot 0 destination index (0 = none) |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 1 | Slot 1 class: 0 arithmetic, 1 logic |
| s1_mem | input | 1 | Slot 1 accesses data memory |
| s1_dst | input | REG_IDX_W | Slot 1 destination index |
| s1_srca | input | REG_IDX_W | Slot 1 first source index |
| s1_srcb | input | REG_IDX_W | Slot 1 second source index |
| stall_in | input | 1 | Downstream stall |
| gnt | output | 2 | Registered issue grant per slot |
| unit_sel | output | 2 | Registered unit select per slot: 1 = logic unit |
| mem_en | output | 1 | Registered: an issued instruction uses the memory port |
| mem_slot | output | 1 | Registered: which slot drives the memory port |
| fetch_inc | output | $clog2(2*INSN_BYTES+1) | PC increment in bytes: 0, INSN_BYTES or 2*INSN_BYTES |

## Verification
The bench builds the unit with REG_IDX_W=3 and INSN_BYTES=4. With only eight register indices, index 0 and exact source/destination matches come up in nearly every pattern, so the RAW, WAW and zero-index cases are reached without a large stimulus set. The increments 4 and 8 can be told apart directly on `fetch_inc`. The vector table combines class clashes, memory clashes, invalid slots and stalls. Directed steps then check the one-edge latency of the grants against the same-cycle increment, and an asynchronous reset in the middle of a run.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic {
    CLS_ARITH = 1'b0,
    CLS_LOGIC = 1'b1
  } op_cls_e;

  typedef enum logic [1:0] {
    ADV_HOLD = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_TWO  = 2'd2
  } fetch_adv_e;
endpackage

// File: rtl/dsp_pair_hazard.sv
module dsp_pair_hazard
  import dsp_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v0,
  input  logic                 c0,
  input  logic                 m0,
  input  logic [REG_IDX_W-1:0] d0,
  input  logic                 v1,
  input  logic                 c1,
  input  logic                 m1,
  input  logic [REG_IDX_W-1:0] d1,
  input  logic [REG_IDX_W-1:0] a1,
  input  logic [REG_IDX_W-1:0] b1,
  input  logic                 stall,
  output logic [1:0]           gnt,
  output fetch_adv_e           adv
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  logic d0_live;
  logic raw_hit, waw_hit, cls_hit, mem_hit;
  logic pair_block;

  always_comb begin
    d0_live    = (d0 != ZERO_IDX);
    raw_hit    = d0_live && ((a1 == d0) || (b1 == d0));
    waw_hit    = d0_live && (d1 == d0);
    cls_hit    = (c0 == c1);
    mem_hit    = m0 && m1;
    pair_block = v0 && v1 && (raw_hit || waw_hit || cls_hit || mem_hit);
  end

  always_comb begin
    gnt[0] = v0 && !stall;
    gnt[1] = v1 && !stall && !pair_block;
    if (stall)           adv = ADV_HOLD;
    else if (pair_block) adv = ADV_ONE;
    else                 adv = ADV_TWO;
  end

  // R6: a younger source reading the older nonzero destination never pairs
  a_r6_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && (d0 != ZERO_IDX) && ((a1 == d0) || (b1 == d0))) |-> !gnt[1]);

  // R5: same nonzero destination keeps the younger write out of this cycle
  a_r5_waw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && (d0 != ZERO_IDX) && (d1 == d0)) |-> !gnt[1]);

  // R9: a held valid younger slot advances fetch by one word
  a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && v1 && !gnt[1]) |-> (adv == ADV_ONE));
endmodule

// File: rtl/dsp_unit_route.sv
module dsp_unit_route #(
  parameter int NUM_SLOTS = 2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] gnt,
  input  logic [NUM_SLOTS-1:0] cls,
  input  logic [NUM_SLOTS-1:0] mem,
  output logic [NUM_SLOTS-1:0] usel,
  output logic                 mem_en,
  output logic [SLOT_W-1:0]    mem_slot
);
  logic [NUM_SLOTS-1:0] mem_req;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign usel[i]    = gnt[i] & cls[i];
    assign mem_req[i] = gnt[i] & mem[i];
  end

  // oldest requesting slot wins the port
  always_comb begin
    mem_en   = |mem_req;
    mem_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (mem_req[i]) mem_slot = SLOT_W'(i);
    end
  end

  // R4: the hazard stage never hands the port to two slots at once
  a_r4_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_req));
endmodule

// File: rtl/dsp_pair_steer.sv
module dsp_pair_steer
  import dsp_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int INSN_BYTES  = 4,
  localparam int INC_W      = $clog2(2 * INSN_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s0_valid,
  input  logic                 s0_cls,
  input  logic                 s0_mem,
  input  logic [REG_IDX_W-1:0] s0_dst,
  input  logic                 s1_valid,
  input  logic                 s1_cls,
  input  logic                 s1_mem,
  input  logic [REG_IDX_W-1:0] s1_dst,
  input  logic [REG_IDX_W-1:0] s1_srca,
  input  logic [REG_IDX_W-1:0] s1_srcb,
  input  logic                 stall_in,
  output logic [1:0]           gnt,
  output logic [1:0]           unit_sel,
  output logic                 mem_en,
  output logic                 mem_slot,
  output logic [INC_W-1:0]     fetch_inc
);
  localparam logic [INC_W-1:0] STEP_ONE = INC_W'(INSN_BYTES);
  localparam logic [INC_W-1:0] STEP_TWO = INC_W'(2 * INSN_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // decision
  logic [1:0]  gnt_d;
  logic [1:0]  usel_d;
  logic        mem_en_d;
  logic        mem_slot_d;
  fetch_adv_e  adv;

  dsp_pair_hazard #(.REG_IDX_W(REG_IDX_W)) u_hazard (
    .clk   (clk),
    .rst_n (rst_q_n),
    .v0    (s0_valid),
    .c0    (s0_cls),
    .m0    (s0_mem),
    .d0    (s0_dst),
    .v1    (s1_valid),
    .c1    (s1_cls),
    .m1    (s1_mem),
    .d1    (s1_dst),
    .a1    (s1_srca),
    .b1    (s1_srcb),
    .stall (stall_in),
    .gnt   (gnt_d),
    .adv   (adv)
  );

  dsp_unit_route #(.NUM_SLOTS(2)) u_route (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .gnt      (gnt_d),
    .cls      ({s1_cls, s0_cls}),
    .mem      ({s1_mem, s0_mem}),
    .usel     (usel_d),
    .mem_en   (mem_en_d),
    .mem_slot (mem_slot_d)
  );

  always_comb begin
    unique case (adv)
      ADV_ONE: fetch_inc = STEP_ONE;
      ADV_TWO: fetch_inc = STEP_TWO;
      default: fetch_inc = '0;
    endcase
  end

  // issue register
  logic [1:0] gnt_q, usel_q;
  logic       mem_en_q, mem_slot_q;
  logic       issue_en;

  assign issue_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q      <= '0;
      usel_q     <= '0;
      mem_en_q   <= 1'b0;
      mem_slot_q <= 1'b0;
    end else if (!rst_q_n) begin
      gnt_q      <= '0;
      usel_q     <= '0;
      mem_en_q   <= 1'b0;
      mem_slot_q <= 1'b0;
    end else if (issue_en) begin
      gnt_q      <= gnt_d;
      usel_q     <= usel_d;
      mem_en_q   <= mem_en_d;
      mem_slot_q <= mem_slot_d;
    end
  end

  assign gnt      = gnt_q;
  assign unit_sel = usel_q;
  assign mem_en   = mem_en_q;
  assign mem_slot = mem_slot_q;

  // R8: a stalled cycle yields an empty issue on the next edge
  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall_in |=> (gnt == 2'b00) && !mem_en);

  // R8: no PC movement under stall
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall_in |-> (fetch_inc == '0));

  // R3: a dual issue always uses both distinct units
  a_r3_split_units: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gnt == 2'b11) |-> (unit_sel[0] != unit_sel[1]));

  // R2: slot 0 lands on the unit matching the class it was presented with
  a_r2_steer_slot0: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_sync[1]) or (gnt[0] |-> (unit_sel[0] == $past(s0_cls))));
endmodule

// File: tb/dsp_pair_steer_bench.sv
`timescale 1ns/1ps
module dsp_pair_steer_bench;
  localparam int RW = 3;
  localparam int IB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          s0_valid, s0_cls, s0_mem;
  logic [RW-1:0] s0_dst;
  logic          s1_valid, s1_cls, s1_mem;
  logic [RW-1:0] s1_dst, s1_srca, s1_srcb;
  logic          stall_in;
  logic [1:0]    gnt, unit_sel;
  logic          mem_en, mem_slot;
  logic [3:0]    fetch_inc;

  always #2 clk = ~clk;

  dsp_pair_steer #(.REG_IDX_W(RW), .INSN_BYTES(IB)) u_dsp_pair_steer (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_mem(s0_mem), .s0_dst(s0_dst),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_mem(s1_mem), .s1_dst(s1_dst),
    .s1_srca(s1_srca), .s1_srcb(s1_srcb), .stall_in(stall_in),
    .gnt(gnt), .unit_sel(unit_sel), .mem_en(mem_en), .mem_slot(mem_slot),
    .fetch_inc(fetch_inc)
  );

  typedef struct packed {
    logic [7:0]    rq;
    logic          v0, c0, m0;
    logic [RW-1:0] d0;
    logic          v1, c1, m1;
    logic [RW-1:0] d1, a1, b1;
    logic          st;
    logic [1:0]    eg, eu;
    logic          eme, ems;
    logic [3:0]    einc;
  } tv_t;

  localparam int NV = 16;
  localparam tv_t TV [NV] = '{
    // R2 arith + logic pair
    '{8'd2, 1'b1,1'b0,1'b0,3'd1, 1'b1,1'b1,1'b0,3'd4,3'd5,3'd6, 1'b0, 2'b11,2'b10,1'b0,1'b0,4'd8},
    // R2 logic + arith pair
    '{8'd2, 1'b1,1'b1,1'b0,3'd1, 1'b1,1'b0,1'b0,3'd2,3'd3,3'd4, 1'b0, 2'b11,2'b01,1'b0,1'b0,4'd8},
    // R3 both arith
    '{8'd3, 1'b1,1'b0,1'b0,3'd1, 1'b1,1'b0,1'b0,3'd2,3'd3,3'd4, 1'b0, 2'b01,2'b00,1'b0,1'b0,4'd4},
    // R3 both logic
    '{8'd3, 1'b1,1'b1,1'b0,3'd1, 1'b1,1'b1,1'b0,3'd2,3'd3,3'd4, 1'b0, 2'b01,2'b01,1'b0,1'b0,4'd4},
    // R4 both memory
    '{8'd4, 1'b1,1'b0,1'b1,3'd1, 1'b1,1'b1,1'b1,3'd2,3'd3,3'd4, 1'b0, 2'b01,2'b00,1'b1,1'b0,4'd4},
    // R4 only slot 1 valid and memory
    '{8'd4, 1'b0,1'b0,1'b0,3'd0, 1'b1,1'b1,1'b1,3'd2,3'd3,3'd4, 1'b0, 2'b10,2'b10,1'b1,1'b1,4'd8},
    // R5 same destination
    '{8'd5, 1'b1,1'b0,1'b0,3'd3, 1'b1,1'b1,1'b0,3'd3,3'd1,3'd2, 1'b0, 2'b01,2'b00,1'b0,1'b0,4'd4},
    // R6 source a reads older dest
    '{8'd6, 1'b1,1'b0,1'b0,3'd5, 1'b1,1'b1,1'b0,3'd2,3'd5,3'd1, 1'b0, 2'b01,2'b00,1'b0,1'b0,4'd4},
    // R6 source b reads older dest
    '{8'd6, 1'b1,1'b0,1'b0,3'd5, 1'b1,1'b1,1'b0,3'd2,3'd1,3'd5, 1'b0, 2'b01,2'b00,1'b0,1'b0,4'd4},
    // R7 index 0 everywhere
    '{8'd7, 1'b1,1'b0,1'b0,3'd0, 1'b1,1'b1,1'b0,3'd0,3'd0,3'd0, 1'b0, 2'b11,2'b10,1'b0,1'b0,4'd8},
    // R8 stall on an independent pair
    '{8'd8, 1'b1,1'b0,1'b0,3'd1, 1'b1,1'b1,1'b0,3'd4,3'd5,3'd6, 1'b1, 2'b00,2'b00,1'b0,1'b0,4'd0},
    // R9 both invalid
    '{8'd9, 1'b0,1'b0,1'b0,3'd1, 1'b0,1'b0,1'b0,3'd1,3'd1,3'd1, 1'b0, 2'b00,2'b00,1'b0,1'b0,4'd8},
    // R9 slot 1 invalid, would clash if valid
    '{8'd9, 1'b1,1'b1,1'b0,3'd1, 1'b0,1'b1,1'b0,3'd1,3'd1,3'd1, 1'b0, 2'b01,2'b01,1'b0,1'b0,4'd8},
    // R4 slot 0 memory, slot 1 not
    '{8'd4, 1'b1,1'b1,1'b1,3'd1, 1'b1,1'b0,1'b0,3'd2,3'd3,3'd4, 1'b0, 2'b11,2'b01,1'b1,1'b0,4'd8},
    // R4 slot 1 memory alongside slot 0
    '{8'd4, 1'b1,1'b0,1'b0,3'd1, 1'b1,1'b1,1'b1,3'd2,3'd3,3'd4, 1'b0, 2'b11,2'b10,1'b1,1'b1,4'd8},
    // R8 stall with memory op
    '{8'd8, 1'b1,1'b0,1'b1,3'd1, 1'b1,1'b1,1'b0,3'd4,3'd5,3'd6, 1'b1, 2'b00,2'b00,1'b0,1'b0,4'd0}
  };

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input tv_t t);
    s0_valid = t.v0; s0_cls = t.c0; s0_mem = t.m0; s0_dst = t.d0;
    s1_valid = t.v1; s1_cls = t.c1; s1_mem = t.m1; s1_dst = t.d1;
    s1_srca = t.a1; s1_srcb = t.b1; stall_in = t.st;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(TV[11]);
    repeat (3) @(negedge clk);
    // R1 outputs quiet under reset
    chk("R1 gnt in reset", int'(gnt), 0);
    chk("R1 unit_sel in reset", int'(unit_sel), 0);
    chk("R1 mem_en in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TV[i]);
      #1;
      chk($sformatf("R%0d vec%0d fetch_inc", TV[i].rq, i), int'(fetch_inc), int'(TV[i].einc));
      @(posedge clk);
      #1;
      chk($sformatf("R%0d vec%0d gnt", TV[i].rq, i), int'(gnt), int'(TV[i].eg));
      chk($sformatf("R%0d vec%0d unit_sel", TV[i].rq, i), int'(unit_sel), int'(TV[i].eu));
      chk($sformatf("R%0d vec%0d mem_en", TV[i].rq, i), int'(mem_en), int'(TV[i].eme));
      if (TV[i].eme)
        chk($sformatf("R%0d vec%0d mem_slot", TV[i].rq, i), int'(mem_slot), int'(TV[i].ems));
    end

    // R10 grants lag one edge, increment follows at once
    @(negedge clk);
    drive(TV[0]);
    #1;
    chk("R10 gnt before edge", int'(gnt), 0);
    chk("R10 fetch_inc same cycle", int'(fetch_inc), 8);
    @(posedge clk);
    #1;
    chk("R10 gnt after edge", int'(gnt), 3);

    // R1 reset in mid run clears outputs without a clock edge
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R1 async clear gnt", int'(gnt), 0);
    chk("R1 async clear unit_sel", int'(unit_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 held during sync release", int'(gnt), 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 issue resumes after release", int'(gnt), 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule